// File: doc/BRIEF.md
# Reconfiguration Sequencing Controller

This block walks a program held in a synchronous memory and turns it into traffic on the serial configuration bus of a fine-grain reconfigurable tile array. Each program word is an instruction. The instruction can latch a row index or a column index. It can pick one of the four configuration chains inside the addressed tile and stream a counted number of payload bits into it. It can also drop all tile selects, or fire the array's global reset. Payload bits go out one at a time on a single data line. A dedicated configuration clock carries them, with one rising edge per bit.

A host loads the program memory, pulses `go` and waits. While the program runs, `busy` is high. The program ends in one of two ways. A start instruction pulses the array reset and then raises `done`. An opcode the sequencer does not recognise stops execution and raises `err`. The output-connection stage of the addressed tile must not fight the shifting chain. For that reason the block raises a disable line during every shift into chains 0 to 2. A shift into the reset-mask chain leaves the disable line low, so running logic is not disturbed.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `arr_rst`, `cfg_clk`, `cfg_data`, `mem_rd_en` and `out_disable` are low, and `row_sel` and `col_sel` are all zero.
- R2: An instruction word holds the opcode in bits [15:12] and the operand in bits [11:0]. The opcodes are: 1 row, 2 column, 3 output connections (chain 0), 4 input connections plus logic (chain 1), 5 switch box (chain 2), 6 reset mask (chain 3), 7 deselect, 8 start. Every other opcode is unknown.
- R3: After a row (column) instruction, selection is active and `row_sel` (`col_sel`) has exactly bit `operand` set. If the operand is N+2 or more, the vector is all zero.
- R4: For opcodes 3 to 5, the operand is a bit count n. The next ceil(n/16) memory words are the payload and are sent MSB first. Each bit gives exactly one rising edge of `cfg_clk`, and `cfg_data` and `chain_sel` are stable at that edge. When n is 0, no word is consumed and no edge occurs. The next instruction is the word after the payload.
- R5: A reset-mask instruction (opcode 6) sends operand bit 0 as a single bit on chain 3 without reading any payload word, and keeps `out_disable` low.
- R6: `out_disable` is high at every `cfg_clk` rising edge on chains 0 to 2.
- R7: A deselect instruction drives every line of `row_sel` and `col_sel` low, and these lines stay low until the next row or column instruction.
- R8: A start instruction holds `arr_rst` high for exactly RST_CYC (default 2) clock cycles. In the cycle `arr_rst` falls, `done` rises and `busy` falls.
- R9: An unknown opcode raises `err` and drops `busy`. No further memory read and no further configuration edge occurs until the next `go`.
- R10: `go` in idle clears `done` and `err` and starts fetching at address 0. Memory read data is used one cycle after `mem_rd_en`. Cycle costs are: 2 for each non-shifting instruction, 2+2·words+2·n+1 for a configure with n>0, 5 for a mask, and 4 for a start up to `done`.
- R11: `cfg_clk` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Host start pulse, taken in idle |
| mem_rdata | input | 16 | Program memory read data, one cycle after request |
| mem_rd_en | output | 1 | Program memory read request |
| mem_addr | output | ADDR_W (8) | Program memory word address |
| row_sel | output | N_GRID+2 (10) | One-hot tile row select |
| col_sel | output | N_GRID+2 (10) | One-hot tile column select |
| chain_sel | output | 2 | Chain within the tile |
| cfg_data | output | 1 | Serial configuration bit |
| cfg_clk | output | 1 | Configuration clock, rising edge per bit |
| out_disable | output | 1 | Disables tile output connections while chains 0-2 shift |
| arr_rst | output | 1 | Global array reset pulse |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended with a start instruction |
| err | output | 1 | Program halted on an unknown opcode |

## Verification
A corrupted program counter or payload counter shows up at the ports as a wrong bit value, a wrong number of `cfg_clk` rising edges or a shifted end time. The bench therefore compares every rising edge against a queue built from the program. It also compares the cycle count from `go` to `done`/`err` with the cost formula, so a single lost or extra cycle is caught by the end of the run. A bad select or chain register is visible at the very edge where a bit is clocked. A reset-pulse counter fault is visible when `arr_rst` falls.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int ARG_W  = WORD_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_ROW   = 4'h1,
        OP_COL   = 4'h2,
        OP_OUTC  = 4'h3,
        OP_INC   = 4'h4,
        OP_SWB   = 4'h5,
        OP_MASK  = 4'h6,
        OP_DESEL = 4'h7,
        OP_START = 4'h8
    } opcode_e;

    typedef enum logic [1:0] {
        CH_OUTC = 2'd0,
        CH_INC  = 2'd1,
        CH_SWB  = 2'd2,
        CH_MASK = 2'd3
    } chain_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_EXEC, S_LOAD, S_LATCH,
        S_LO, S_HI, S_END, S_RST
    } state_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } instr_t;

    function automatic logic is_shift_op(input logic [OP_W-1:0] op);
        return (op == OP_OUTC) || (op == OP_INC) || (op == OP_SWB);
    endfunction

    function automatic chain_e chain_of(input logic [OP_W-1:0] op);
        case (op)
            OP_OUTC: return CH_OUTC;
            OP_INC:  return CH_INC;
            OP_SWB:  return CH_SWB;
            default: return CH_MASK;
        endcase
    endfunction

endpackage

// File: rtl/cfg_sel_dec.sv
module cfg_sel_dec #(
    parameter int LINES = 10,
    parameter int IDX_W = 12
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [LINES-1:0] sel
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign sel[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/cfg_shift_unit.sv
module cfg_shift_unit #(
    parameter int W     = 16,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             ld_single,
    input  logic             single_bit,
    input  logic             ld_word,
    input  logic [W-1:0]     word_in,
    input  logic             drive_lo,
    input  logic             drive_hi,
    input  logic             park,
    output logic             cfg_clk,
    output logic             cfg_data,
    output logic             last_bit,
    output logic             word_end
);
    localparam int POS_W = $clog2(W);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] left_q;
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            left_q   <= '0;
            pos_q    <= '0;
            cfg_clk  <= 1'b0;
            cfg_data <= 1'b0;
        end else begin
            if (ld_cnt) begin
                left_q <= cnt_in;
                pos_q  <= '0;
            end
            if (ld_single) begin
                sh_q   <= {single_bit, {(W-1){1'b0}}};
                left_q <= CNT_W'(1);
                pos_q  <= '0;
            end
            if (ld_word) begin
                sh_q  <= word_in;
                pos_q <= '0;
            end
            if (drive_lo) begin
                cfg_data <= sh_q[W-1];
                cfg_clk  <= 1'b0;
            end
            if (drive_hi) begin
                cfg_clk <= 1'b1;
                sh_q    <= sh_q << 1;
                left_q  <= left_q - CNT_W'(1);
                pos_q   <= pos_q + POS_W'(1);
            end
            if (park) begin
                cfg_clk <= 1'b0;
            end
        end
    end

    assign last_bit = (left_q == CNT_W'(1));
    assign word_end = (pos_q == POS_W'(W-1));
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int RST_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              last_bit,
    input  logic              word_end,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ARG_W-1:0]  row_idx,
    output logic [ARG_W-1:0]  col_idx,
    output logic              sel_on,
    output logic [1:0]        chain_sel,
    output logic              out_dis,
    output logic              arr_rst,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ld_cnt,
    output logic [ARG_W-1:0]  cnt_val,
    output logic              ld_single,
    output logic              single_bit,
    output logic              ld_word,
    output logic              drive_lo,
    output logic              drive_hi,
    output logic              park
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    state_e            state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [RC_W-1:0]   rcnt_q;
    chain_e            chain_q;
    instr_t            ins;

    assign ins = instr_t'(mem_rdata);

    always_comb begin
        mem_rd_en  = (state_q == S_FETCH) || (state_q == S_LOAD);
        mem_addr   = pc_q;
        busy       = (state_q != S_IDLE);
        chain_sel  = chain_q;
        out_dis    = (state_q inside {S_LOAD, S_LATCH, S_LO, S_HI, S_END})
                     && (chain_q != CH_MASK);
        ld_cnt     = (state_q == S_EXEC) && is_shift_op(ins.op);
        cnt_val    = ins.arg;
        ld_single  = (state_q == S_EXEC) && (ins.op == OP_MASK);
        single_bit = ins.arg[0];
        ld_word    = (state_q == S_LATCH);
        drive_lo   = (state_q == S_LO);
        drive_hi   = (state_q == S_HI);
        park       = (state_q == S_END)
                     || ((state_q == S_EXEC) && (ins.op == OP_DESEL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            rcnt_q  <= '0;
            chain_q <= CH_OUTC;
            row_idx <= '0;
            col_idx <= '0;
            sel_on  <= 1'b0;
            arr_rst <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (go) begin
                        pc_q    <= '0;
                        done    <= 1'b0;
                        err     <= 1'b0;
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    pc_q    <= pc_q + ADDR_W'(1);
                    state_q <= S_EXEC;
                end
                S_EXEC: begin
                    case (ins.op)
                        OP_ROW: begin
                            row_idx <= ins.arg;
                            sel_on  <= 1'b1;
                            state_q <= S_FETCH;
                        end
                        OP_COL: begin
                            col_idx <= ins.arg;
                            sel_on  <= 1'b1;
                            state_q <= S_FETCH;
                        end
                        OP_OUTC, OP_INC, OP_SWB: begin
                            chain_q <= chain_of(ins.op);
                            state_q <= (ins.arg == '0) ? S_FETCH : S_LOAD;
                        end
                        OP_MASK: begin
                            chain_q <= CH_MASK;
                            state_q <= S_LO;
                        end
                        OP_DESEL: begin
                            sel_on  <= 1'b0;
                            state_q <= S_FETCH;
                        end
                        OP_START: begin
                            arr_rst <= 1'b1;
                            rcnt_q  <= '0;
                            state_q <= S_RST;
                        end
                        default: begin
                            err     <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    endcase
                end
                S_LOAD: begin
                    pc_q    <= pc_q + ADDR_W'(1);
                    state_q <= S_LATCH;
                end
                S_LATCH: state_q <= S_LO;
                S_LO:    state_q <= S_HI;
                S_HI: begin
                    if (last_bit)      state_q <= S_END;
                    else if (word_end) state_q <= S_LOAD;
                    else               state_q <= S_LO;
                end
                S_END: state_q <= S_FETCH;
                S_RST: begin
                    if (rcnt_q == RC_W'(RST_CYC - 1)) begin
                        arr_rst <= 1'b0;
                        done    <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        rcnt_q <= rcnt_q + RC_W'(1);
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int N_GRID  = 8,
    parameter int ADDR_W  = 8,
    parameter int RST_CYC = 2,
    localparam int SEL_N  = N_GRID + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [15:0]       mem_rdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [SEL_N-1:0]  row_sel,
    output logic [SEL_N-1:0]  col_sel,
    output logic [1:0]        chain_sel,
    output logic              cfg_data,
    output logic              cfg_clk,
    output logic              out_disable,
    output logic              arr_rst,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic [ARG_W-1:0] row_idx, col_idx, cnt_val;
    logic sel_on, ld_cnt, ld_single, single_bit, ld_word;
    logic drive_lo, drive_hi, park, last_bit, word_end;

    cfg_seq_fsm #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_fsm (
        .clk(clk), .rst(rst), .go(go), .mem_rdata(mem_rdata),
        .last_bit(last_bit), .word_end(word_end),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .row_idx(row_idx), .col_idx(col_idx), .sel_on(sel_on),
        .chain_sel(chain_sel), .out_dis(out_disable), .arr_rst(arr_rst),
        .busy(busy), .done(done), .err(err),
        .ld_cnt(ld_cnt), .cnt_val(cnt_val), .ld_single(ld_single),
        .single_bit(single_bit), .ld_word(ld_word),
        .drive_lo(drive_lo), .drive_hi(drive_hi), .park(park)
    );

    cfg_shift_unit #(.W(WORD_W), .CNT_W(ARG_W)) u_shift (
        .clk(clk), .rst(rst),
        .ld_cnt(ld_cnt), .cnt_in(cnt_val),
        .ld_single(ld_single), .single_bit(single_bit),
        .ld_word(ld_word), .word_in(mem_rdata),
        .drive_lo(drive_lo), .drive_hi(drive_hi), .park(park),
        .cfg_clk(cfg_clk), .cfg_data(cfg_data),
        .last_bit(last_bit), .word_end(word_end)
    );

    cfg_sel_dec #(.LINES(SEL_N), .IDX_W(ARG_W)) u_row_dec (
        .en(sel_on), .idx(row_idx), .sel(row_sel)
    );

    cfg_sel_dec #(.LINES(SEL_N), .IDX_W(ARG_W)) u_col_dec (
        .en(sel_on), .idx(col_idx), .sel(col_sel)
    );
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
    parameter int SEL_N   = 10,
    parameter int RST_CYC = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             mem_rd_en,
    input logic [SEL_N-1:0] row_sel,
    input logic [SEL_N-1:0] col_sel,
    input logic [1:0]       chain_sel,
    input logic             cfg_clk,
    input logic             out_disable,
    input logic             arr_rst,
    input logic             busy,
    input logic             done,
    input logic             err
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)          hi_cnt <= '0;
        else if (arr_rst) hi_cnt <= hi_cnt + 8'd1;
        else              hi_cnt <= '0;
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel) && $onehot0(col_sel));

    // R6
    shift_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_clk) && chain_sel != 2'd3) |-> out_disable);

    // R8
    rst_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(arr_rst) |-> (hi_cnt == 8'(RST_CYC)) && done && !busy);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !go) |=> !mem_rd_en && !cfg_clk);

    // R11
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cfg_clk);
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.SEL_N(SEL_N), .RST_CYC(RST_CYC)) u_chk (
    .clk(clk), .rst(rst), .go(go), .mem_rd_en(mem_rd_en),
    .row_sel(row_sel), .col_sel(col_sel), .chain_sel(chain_sel),
    .cfg_clk(cfg_clk), .out_disable(out_disable), .arr_rst(arr_rst),
    .busy(busy), .done(done), .err(err)
);

// File: tb/tb_cfg_seq_ctrl.sv
module tb_cfg_seq_ctrl;
    localparam int SEL_N = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic mem_rd_en;
    logic [7:0] mem_addr;
    logic [SEL_N-1:0] row_sel, col_sel;
    logic [1:0] chain_sel;
    logic cfg_data, cfg_clk, out_disable, arr_rst, busy, done, err;

    always #10 clk = ~clk;

    cfg_seq_ctrl dut (
        .clk(clk), .rst(rst), .go(go), .mem_rdata(mem_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .row_sel(row_sel), .col_sel(col_sel), .chain_sel(chain_sel),
        .cfg_data(cfg_data), .cfg_clk(cfg_clk), .out_disable(out_disable),
        .arr_rst(arr_rst), .busy(busy), .done(done), .err(err)
    );

    logic [15:0] mem [0:255];
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    int checks = 0;
    int fails  = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model state
    int m_row = 0, m_col = 0;
    bit m_on = 0;
    int wp = 0;
    int exp_cyc = 0;
    bit              q_bit[$];
    int              q_ch[$];
    logic [SEL_N-1:0] q_rv[$];
    logic [SEL_N-1:0] q_cv[$];
    logic [SEL_N-1:0] exp_rst_rv = '0, exp_rst_cv = '0;

    function automatic logic [SEL_N-1:0] vec(input bit on, input int idx);
        logic [SEL_N-1:0] v = '0;
        if (on && idx < SEL_N) v[idx] = 1'b1;
        return v;
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        wp = 0;
        exp_cyc = 0;
    endtask

    task automatic put(input int op, input int arg);
        mem[wp] = {4'(op), 12'(arg)};
        wp++;
        exp_cyc += 2;
        if (op == 1) begin m_row = arg; m_on = 1; end
        if (op == 2) begin m_col = arg; m_on = 1; end
        if (op == 7) m_on = 0;
    endtask

    task automatic push_bit(input bit b, input int ch);
        q_bit.push_back(b);
        q_ch.push_back(ch);
        q_rv.push_back(vec(m_on, m_row));
        q_cv.push_back(vec(m_on, m_col));
    endtask

    task automatic put_cfg(input int op, input int n, input int seed);
        int words = (n + 15) / 16;
        logic [15:0] w [0:255];
        put(op, n);
        for (int i = 0; i < words; i++) begin
            w[i] = 16'(seed * 16'h3B1 + i * 16'h5A93 + 16'hC6);
            mem[wp] = w[i];
            wp++;
        end
        for (int b = 0; b < n; b++) push_bit(w[b/16][15 - (b % 16)], op - 3);
        if (n > 0) exp_cyc += 2 * words + 2 * n + 1;
    endtask

    task automatic put_mask(input bit b);
        put(6, {11'd0, b});
        push_bit(b, 3);
        exp_cyc += 3;
    endtask

    task automatic put_start();
        put(8, 0);
        exp_rst_rv = vec(m_on, m_row);
        exp_rst_cv = vec(m_on, m_col);
        exp_cyc += 2;
    endtask

    // per-clock monitor
    bit prev_clk = 0, prev_rst = 0;
    int rst_hi = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cfg_clk && !prev_clk) begin
                if (q_bit.size() == 0) begin
                    check_eq("R4/R9 unexpected cfg_clk edge", 1, 0);
                end else begin
                    int ch;
                    ch = q_ch.pop_front();
                    check_eq("R4 cfg_data", int'(cfg_data), int'(q_bit.pop_front()));
                    check_eq("R4 chain_sel", int'(chain_sel), ch);
                    check_eq("R3 row_sel at edge", int'(row_sel), int'(q_rv.pop_front()));
                    check_eq("R3 col_sel at edge", int'(col_sel), int'(q_cv.pop_front()));
                    if (ch == 3) check_eq("R5 out_disable low on mask", int'(out_disable), 0);
                    else         check_eq("R6 out_disable at edge", int'(out_disable), 1);
                end
            end
            if (!busy) check_eq("R11 cfg_clk low when idle", int'(cfg_clk), 0);
            if (arr_rst) begin
                rst_hi++;
                check_eq("R7 row_sel during reset", int'(row_sel), int'(exp_rst_rv));
                check_eq("R7 col_sel during reset", int'(col_sel), int'(exp_rst_cv));
            end else if (prev_rst) begin
                check_eq("R8 arr_rst width", rst_hi, 2);
                check_eq("R8 done at fall", int'(done), 1);
                check_eq("R8 busy at fall", int'(busy), 0);
                rst_hi = 0;
            end
        end
        prev_clk = cfg_clk;
        prev_rst = arr_rst;
    end

    task automatic run(input string tag, input bit exp_done, input bit exp_err);
        int cyc = 0;
        @(negedge clk); go = 1'b1;
        @(posedge clk);
        @(negedge clk); go = 1'b0;
        check_eq({tag, " R10 flags cleared by go"}, int'(done | err), 0);
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done || err || cyc > 5000) break;
        end
        check_eq({tag, " R10 cycles go to end"}, cyc, exp_cyc);
        check_eq({tag, " done"}, int'(done), int'(exp_done));
        check_eq({tag, " R9 err"}, int'(err), int'(exp_err));
        check_eq({tag, " busy low"}, int'(busy), 0);
        repeat (4) @(negedge clk);
        check_eq({tag, " R9 no read when halted"}, int'(mem_rd_en), 0);
        check_eq({tag, " R4 all bits seen"}, q_bit.size(), 0);
        q_bit.delete(); q_ch.delete(); q_rv.delete(); q_cv.delete();
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 busy", int'(busy), 0);
        check_eq("R1 flags", int'({done, err, arr_rst}), 0);
        check_eq("R1 cfg lines", int'({cfg_clk, cfg_data, mem_rd_en, out_disable}), 0);
        check_eq("R1 selects", int'(row_sel | col_sel), 0);
        rst = 1'b0;
        @(negedge clk);

        // full sequence on every chain, perimeter column
        clear_prog();
        put(1, 3);
        put(2, 9);
        put_cfg(3, 20, 1);
        put_cfg(4, 5, 2);
        put_cfg(5, 16, 3);
        put_mask(1'b1);
        put_mask(1'b0);
        put_cfg(3, 0, 4);
        put(7, 0);
        put_start();
        run("progA", 1'b1, 1'b0);
        check_eq("R7 row_sel after deselect", int'(row_sel), 0);

        // out-of-range row index
        clear_prog();
        put(1, 12);
        put(2, 0);
        put_cfg(4, 33, 5);
        put_start();
        run("progB R3 range", 1'b1, 1'b0);

        // unknown opcode after a select, trailing configure never runs
        clear_prog();
        put(1, 1);
        mem[wp] = 16'hB000; wp++; exp_cyc += 2;
        mem[wp] = {4'h3, 12'd4}; wp++;
        mem[wp] = 16'hFFFF; wp++;
        run("progC R9", 1'b0, 1'b1);
        check_eq("R3 row held after halt", int'(row_sel), 2);

        // opcode zero is unknown
        clear_prog();
        mem[0] = 16'h0123; exp_cyc = 2;
        run("progD R2", 1'b0, 1'b1);

        // go clears error, start alone
        clear_prog();
        put_start();
        run("progE R10", 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule